// File: doc/BRIEF.md
# Coarse-Grain ALU Tile with Banked Register Memory

This block is an 8-bit processing tile that combines a small word memory with a fixed-function ALU. Every control, address and data input is captured in a register on the rising clock edge, so one tile forms exactly one pipeline stage. During the cycle after capture, the memory is read combinationally at the captured addresses, the ALU works on those operands, and the result appears on `result_o`. The write-back commits on the next rising edge. A read, an operation and a write-back to the same word, such as A op B into A, therefore complete in one cycle.

The memory is built from two banks of 128 words. In single-port mode the banks form one 256-word space: the top address bit picks the bank, the A operand comes from memory, and the B operand comes from the data input. In dual-port mode every write goes to both banks, so each bank keeps a full copy. The A operand is then read from one bank and the B operand from the other, which gives two reads with no added latency. The cost is that usable depth falls to 128 words.

Either ALU input can be inverted before the operation. This gives NOT, NAND, NOR and subtraction. The carry input and carry output let several tiles be chained into a wider word for add and shift operations. A multiply places its low byte on `result_o` and its high byte in a separate output register.

Top module: `cg_alu_tile`

## Requirements
- R1: After reset, all captured inputs are zero (opcode AND, single-port mode, data 0, no write). As a result, `result_o`, `carry_o` and `hi_o` are all 0.
- R2: Every input is registered. A change between two rising edges does not reach `result_o` until the next rising edge.
- R3: Single-port mode (`dual_mode_i`=0) addresses 256 words with the 8-bit `addr_a_i`. Operand A is the word at that address, and operand B is `data_i`.
- R4: Dual-port mode (`dual_mode_i`=1) uses only address bits 6:0, giving 128 words. Operand A is read at `addr_a_i` and operand B at `addr_b_i`. A write stores the word in both banks, so after a dual-port write at index i, single-port reads of i and of i+128 both return it.
- R5: A write with `wr_en_i`=1 commits on the rising edge that ends the operating cycle. `wr_src_i`=0 stores the ALU result and `wr_src_i`=1 stores `data_i`. A result written back to its own source address can be read in the very next cycle.
- R6: Opcodes 0, 1 and 2 give AND, OR and XOR, with `carry_o`=0.
- R7: Opcode 3 computes A+B+`carry_i`. The low 8 bits go to `result_o` and bit 8 goes to `carry_o`.
- R8: `inv_a_i` and `inv_b_i` complement the respective operand before every operation. B inverted with `carry_i`=1 under opcode 3 yields A-B, and `carry_o`=1 means no borrow occurred.
- R9: Opcode 4 shifts A left and fills bit 0 with 0. Opcode 5 shifts A left and fills bit 0 with `carry_i`. Both output the old bit 7 on `carry_o`. Opcode 6 shifts A right and fills bit 7 with 0. Opcode 7 shifts A right and fills bit 7 with `carry_i`. Both right shifts output the old bit 0 on `carry_o`.
- R10: Opcode 8 multiplies A by B. The low byte goes to `result_o` with `carry_o`=0, and the high byte is loaded into `hi_o` on the next rising edge. `hi_o` holds its value during any other opcode.
- R11: Feeding the `carry_o` of a lower byte into `carry_i` for the next byte reproduces a multi-byte sum. This lets tiles be chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_mode_i | input | 1 | 1 selects dual-port memory mode |
| op_i | input | 4 | ALU opcode |
| inv_a_i | input | 1 | Complement operand A |
| inv_b_i | input | 1 | Complement operand B |
| carry_i | input | 1 | Carry in from the neighbouring tile |
| addr_a_i | input | 8 | Read address for operand A |
| addr_b_i | input | 8 | Read address for operand B (dual-port mode) |
| wr_en_i | input | 1 | Write enable |
| wr_src_i | input | 1 | Write source: 0 ALU result, 1 data input |
| wr_addr_i | input | 8 | Write address |
| data_i | input | 8 | Data input, and operand B in single-port mode |
| result_o | output | 8 | ALU result |
| carry_o | output | 1 | Carry out |
| hi_o | output | 8 | Registered high byte of the last multiply |

## Verification
Single-port reads at addresses that differ only in bit 7 confirm that the bank bit is decoded. Dual-port writes followed by single-port reads of both mirror locations confirm that a write reaches both banks, and dual-port reads with bit 7 set confirm that bit 7 is ignored. Adds and shifts are run with carry-in both 0 and 1, and with operands chosen so that carry-out is 1 in some cases and 0 in others. Subtraction is run in both orders, so the borrow and no-borrow cases are both covered. A read-op-write-back to the source address, followed at once by a read, shows whether the write lands one edge later. A mid-cycle input change shows whether the inputs are truly registered.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  localparam int TILE_W  = 8;
  localparam int TILE_AW = 8;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SHL  = 4'd4,
    OP_SHLC = 4'd5,
    OP_SHR  = 4'd6,
    OP_SHRC = 4'd7,
    OP_MUL  = 4'd8
  } alu_op_e;

  typedef struct packed {
    alu_op_e             op;
    logic                inv_a;
    logic                inv_b;
    logic                cin;
    logic                dual;
    logic                wr_en;
    logic                wr_src;
    logic [TILE_AW-1:0]  addr_a;
    logic [TILE_AW-1:0]  addr_b;
    logic [TILE_AW-1:0]  wr_addr;
    logic [TILE_W-1:0]   data;
  } tile_ctl_t;

  // {carry, sum}
  function automatic logic [TILE_W:0] add_wide(input logic [TILE_W-1:0] a,
                                               input logic [TILE_W-1:0] b,
                                               input logic cin);
    return {1'b0, a} + {1'b0, b} + {{TILE_W{1'b0}}, cin};
  endfunction

  function automatic logic [2*TILE_W-1:0] mul_wide(input logic [TILE_W-1:0] a,
                                                   input logic [TILE_W-1:0] b);
    return {{TILE_W{1'b0}}, a} * {{TILE_W{1'b0}}, b};
  endfunction

  // {bit shifted out, shifted word}
  function automatic logic [TILE_W:0] shift_left(input logic [TILE_W-1:0] a,
                                                 input logic fill);
    return {a, fill};
  endfunction

  function automatic logic [TILE_W:0] shift_right(input logic [TILE_W-1:0] a,
                                                  input logic fill);
    return {a[0], fill, a[TILE_W-1:1]};
  endfunction
endpackage

// File: rtl/cgt_in_regs.sv
module cgt_in_regs #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] d,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cgt_mem.sv
module cgt_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);
  localparam int NBANK = 2;
  localparam int BW    = AW - 1;
  localparam int BD    = 1 << BW;

  logic [DW-1:0]    ra_g [NBANK];
  logic [DW-1:0]    rb_g [NBANK];
  logic [NBANK-1:0] we_vec;

  for (genvar g = 0; g < NBANK; g++) begin : gen_bank
    logic [DW-1:0] ram [BD];

    assign we_vec[g] = wr_en && (dual || (wr_addr[AW-1] == 1'(g)));

    always_ff @(posedge clk) begin
      if (we_vec[g]) ram[wr_addr[BW-1:0]] <= wr_data;
    end

    assign ra_g[g] = ram[addr_a[BW-1:0]];
    assign rb_g[g] = ram[addr_b[BW-1:0]];

    // R5
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_vec[g] |=> ram[$past(wr_addr[BW-1:0])] == $past(wr_data));
  end

  assign rd_a = dual ? ra_g[0] : ra_g[addr_a[AW-1]];
  assign rd_b = rb_g[1];

  // R4
  dual_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dual) |-> (we_vec == {NBANK{1'b1}}));

  // R3
  single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dual) |-> ($countones(we_vec) == 1));
endmodule

// File: rtl/cgt_alu.sv
module cgt_alu
  import cgt_pkg::*;
#(
  parameter int DW = TILE_W
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            inv_a,
  input  logic            inv_b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output logic            cout,
  output logic [DW-1:0]   prod_hi,
  output logic [DW-1:0]   a_eff,
  output logic [DW-1:0]   b_eff
);
  logic [DW:0]     sum;
  logic [2*DW-1:0] prod;
  logic [DW:0]     shl0, shlc, shr0, shrc;

  assign a_eff   = inv_a ? ~a : a;
  assign b_eff   = inv_b ? ~b : b;
  assign sum     = add_wide(a_eff, b_eff, cin);
  assign prod    = mul_wide(a_eff, b_eff);
  assign prod_hi = prod[2*DW-1:DW];
  assign shl0    = shift_left(a_eff, 1'b0);
  assign shlc    = shift_left(a_eff, cin);
  assign shr0    = shift_right(a_eff, 1'b0);
  assign shrc    = shift_right(a_eff, cin);

  always_comb begin
    res  = '0;
    cout = 1'b0;
    unique case (op)
      OP_AND:  res = a_eff & b_eff;
      OP_OR:   res = a_eff | b_eff;
      OP_XOR:  res = a_eff ^ b_eff;
      OP_ADD:  {cout, res} = sum;
      OP_SHL:  {cout, res} = shl0;
      OP_SHLC: {cout, res} = shlc;
      OP_SHR:  {cout, res} = shr0;
      OP_SHRC: {cout, res} = shrc;
      OP_MUL:  res = prod[DW-1:0];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/cg_alu_tile.sv
module cg_alu_tile
  import cgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dual_mode_i,
  input  logic [3:0]         op_i,
  input  logic               inv_a_i,
  input  logic               inv_b_i,
  input  logic               carry_i,
  input  logic [TILE_AW-1:0] addr_a_i,
  input  logic [TILE_AW-1:0] addr_b_i,
  input  logic               wr_en_i,
  input  logic               wr_src_i,
  input  logic [TILE_AW-1:0] wr_addr_i,
  input  logic [TILE_W-1:0]  data_i,
  output logic [TILE_W-1:0]  result_o,
  output logic               carry_o,
  output logic [TILE_W-1:0]  hi_o
);
  localparam int DW = TILE_W;
  localparam int AW = TILE_AW;
  localparam int CW = $bits(tile_ctl_t);

  tile_ctl_t     ctl_d, ctl_q;
  logic [DW-1:0] rd_a, rd_b, opnd_b, wr_data;
  logic [DW-1:0] prod_hi, a_eff, b_eff;
  logic          is_logic_op;

  always_comb begin
    ctl_d.op      = alu_op_e'(op_i);
    ctl_d.inv_a   = inv_a_i;
    ctl_d.inv_b   = inv_b_i;
    ctl_d.cin     = carry_i;
    ctl_d.dual    = dual_mode_i;
    ctl_d.wr_en   = wr_en_i;
    ctl_d.wr_src  = wr_src_i;
    ctl_d.addr_a  = addr_a_i;
    ctl_d.addr_b  = addr_b_i;
    ctl_d.wr_addr = wr_addr_i;
    ctl_d.data    = data_i;
  end

  cgt_in_regs #(.CW(CW)) u_in_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_d),
    .q     (ctl_q)
  );

  cgt_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .dual    (ctl_q.dual),
    .addr_a  (ctl_q.addr_a),
    .addr_b  (ctl_q.addr_b),
    .wr_en   (ctl_q.wr_en),
    .wr_addr (ctl_q.wr_addr),
    .wr_data (wr_data),
    .rd_a    (rd_a),
    .rd_b    (rd_b)
  );

  assign opnd_b = ctl_q.dual ? rd_b : ctl_q.data;

  cgt_alu #(.DW(DW)) u_alu (
    .op      (ctl_q.op),
    .a       (rd_a),
    .b       (opnd_b),
    .inv_a   (ctl_q.inv_a),
    .inv_b   (ctl_q.inv_b),
    .cin     (ctl_q.cin),
    .res     (result_o),
    .cout    (carry_o),
    .prod_hi (prod_hi),
    .a_eff   (a_eff),
    .b_eff   (b_eff)
  );

  assign wr_data = ctl_q.wr_src ? ctl_q.data : result_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_o <= '0;
    else if (ctl_q.op == OP_MUL) hi_o <= prod_hi;
  end

  assign is_logic_op = (ctl_q.op == OP_AND) || (ctl_q.op == OP_OR) ||
                       (ctl_q.op == OP_XOR);

  // R10
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.op == OP_MUL) |=> hi_o == $past(prod_hi));

  // R10
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.op != OP_MUL) |=> $stable(hi_o));

  // R6
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic_op |-> !carry_o);

  // R9
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.op == OP_SHL) |-> (result_o[0] == 1'b0) && (carry_o == a_eff[DW-1]));

  // R9
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.op == OP_SHR) |-> (result_o[DW-1] == 1'b0) && (carry_o == a_eff[0]));

  // R7
  add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.op == OP_ADD && !ctl_q.cin && b_eff == '0) |-> (result_o == a_eff) && !carry_o);
endmodule

// File: tb/cg_alu_tile_tb_top.sv
module cg_alu_tile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dual_mode_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic       inv_a_i = 1'b0, inv_b_i = 1'b0, carry_i = 1'b0;
  logic [7:0] addr_a_i = 8'd0, addr_b_i = 8'd0, wr_addr_i = 8'd0, data_i = 8'd0;
  logic       wr_en_i = 1'b0, wr_src_i = 1'b0;
  logic [7:0] result_o, hi_o;
  logic       carry_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [7:0] mdl [256];

  always #10 clk = ~clk;

  cg_alu_tile dut_i (
    .clk(clk), .rst_n(rst_n), .dual_mode_i(dual_mode_i), .op_i(op_i),
    .inv_a_i(inv_a_i), .inv_b_i(inv_b_i), .carry_i(carry_i),
    .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .wr_en_i(wr_en_i),
    .wr_src_i(wr_src_i), .wr_addr_i(wr_addr_i), .data_i(data_i),
    .result_o(result_o), .carry_o(carry_o), .hi_o(hi_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operating cycle, then sample just after the capturing edge.
  task automatic step(input int op, input bit ia, input bit ib, input bit ci,
                      input bit dm, input bit we, input bit ws,
                      input int aa, input int ab, input int wa, input int d);
    @(negedge clk);
    op_i = 4'(op); inv_a_i = ia; inv_b_i = ib; carry_i = ci;
    dual_mode_i = dm; wr_en_i = we; wr_src_i = ws;
    addr_a_i = 8'(aa); addr_b_i = 8'(ab); wr_addr_i = 8'(wa); data_i = 8'(d);
    @(posedge clk);
    #1;
  endtask

  // Reference ALU written from the requirement text with integer arithmetic.
  function automatic logic [8:0] ref_alu(input int op, input int a0, input int b0,
                                         input bit ia, input bit ib, input bit ci);
    int a, b, s;
    a = ia ? 255 - a0 : a0;
    b = ib ? 255 - b0 : b0;
    case (op)
      0: return {1'b0, 8'(a) & 8'(b)};
      1: return {1'b0, 8'(a) | 8'(b)};
      2: return {1'b0, 8'(a) ^ 8'(b)};
      3: begin s = a + b + int'(ci); return 9'(s); end
      4: return {a >= 128, 8'((a * 2) % 256)};
      5: return {a >= 128, 8'((a * 2) % 256 + int'(ci))};
      6: return {a % 2 == 1, 8'(a / 2)};
      7: return {a % 2 == 1, 8'(a / 2 + 128 * int'(ci))};
      8: return {1'b0, 8'((a * b) % 256)};
      default: return 9'd0;
    endcase
  endfunction

  task automatic load_single(input int adr, input int v);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, adr, v);
    mdl[adr] = 8'(v);
  endtask

  task automatic load_dual(input int adr, input int v);
    step(0, 0, 0, 0, 1, 1, 1, 0, 0, adr, v);
    mdl[adr % 128] = 8'(v);
    mdl[adr % 128 + 128] = 8'(v);
  endtask

  task automatic t_reset();
    chk("R1 result", 16'(result_o), 16'h0);
    chk("R1 carry", 16'(carry_o), 16'h0);
    chk("R1 hi", 16'(hi_o), 16'h0);
  endtask

  task automatic t_single();
    load_single(8'h05, 8'h3C);
    load_single(8'h85, 8'hA7);
    step(0, 0, 0, 0, 0, 0, 0, 8'h05, 0, 0, 8'hFF);
    chk("R3 low bank", 16'(result_o), 16'(mdl[8'h05]));
    step(0, 0, 0, 0, 0, 0, 0, 8'h85, 0, 0, 8'hFF);
    chk("R3 high bank", 16'(result_o), 16'(mdl[8'h85]));
  endtask

  task automatic t_logic();
    for (int op = 0; op < 3; op++) begin
      step(op, 0, 0, 1, 0, 0, 0, 8'h85, 0, 0, 8'h5A);
      chk("R6 logic", {7'd0, carry_o, result_o}, 16'(ref_alu(op, mdl[8'h85], 8'h5A, 0, 0, 1)));
    end
  endtask

  task automatic t_add();
    load_single(8'h10, 8'hF0);
    load_single(8'h11, 8'h7F);
    step(3, 0, 0, 0, 0, 0, 0, 8'h10, 0, 0, 8'h20);
    chk("R7 add carry out", {7'd0, carry_o, result_o}, 16'h0110);
    step(3, 0, 0, 1, 0, 0, 0, 8'h11, 0, 0, 8'h00);
    chk("R7 add carry in", {7'd0, carry_o, result_o}, 16'h0080);
  endtask

  task automatic t_invert();
    load_single(8'h20, 8'h50);
    load_single(8'h21, 8'h20);
    step(1, 1, 0, 0, 0, 0, 0, 8'h20, 0, 0, 8'h00);
    chk("R8 NOT", 16'(result_o), 16'h00AF);
    step(1, 1, 1, 0, 0, 0, 0, 8'h20, 0, 0, 8'h0F);
    chk("R8 NAND", 16'(result_o), 16'h00FF);
    step(0, 1, 1, 0, 0, 0, 0, 8'h20, 0, 0, 8'h0F);
    chk("R8 NOR", 16'(result_o), 16'h00A0);
    step(3, 0, 1, 1, 0, 0, 0, 8'h20, 0, 0, 8'h20);
    chk("R8 sub no borrow", {7'd0, carry_o, result_o}, 16'h0130);
    step(3, 0, 1, 1, 0, 0, 0, 8'h21, 0, 0, 8'h50);
    chk("R8 sub borrow", {7'd0, carry_o, result_o}, 16'h00D0);
  endtask

  task automatic t_shift();
    load_single(8'h30, 8'h81);
    for (int op = 4; op < 8; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        step(op, 0, 0, ci[0], 0, 0, 0, 8'h30, 0, 0, 0);
        chk("R9 shift", {7'd0, carry_o, result_o}, 16'(ref_alu(op, 8'h81, 0, 0, 0, ci[0])));
      end
    end
  endtask

  task automatic t_mul();
    load_single(8'h40, 8'hC8);
    step(8, 0, 0, 1, 0, 0, 0, 8'h40, 0, 0, 8'h0F);
    chk("R10 mul low", {7'd0, carry_o, result_o}, 16'h00B8);
    step(2, 0, 0, 0, 0, 0, 0, 8'h40, 0, 0, 8'h00);
    chk("R10 mul high", 16'(hi_o), 16'h000B);
    step(3, 0, 0, 0, 0, 0, 0, 8'h40, 0, 0, 8'h01);
    chk("R10 hi holds", 16'(hi_o), 16'h000B);
  endtask

  task automatic t_writeback();
    step(3, 0, 0, 0, 0, 1, 0, 8'h05, 0, 8'h05, 8'h01);
    chk("R5 op result", 16'(result_o), 16'h003D);
    mdl[8'h05] = 8'h3D;
    step(0, 0, 0, 0, 0, 0, 0, 8'h05, 0, 0, 8'hFF);
    chk("R5 written back", 16'(result_o), 16'h003D);
  endtask

  task automatic t_dual();
    load_dual(8'h12, 8'h44);
    load_dual(8'h93, 8'h11);
    step(3, 0, 0, 0, 1, 0, 0, 8'h92, 8'h13, 0, 8'hEE);
    chk("R4 dual two reads", 16'(result_o), 16'h0055);
    step(0, 0, 0, 0, 0, 0, 0, 8'h13, 0, 0, 8'hFF);
    chk("R4 mirror low", 16'(result_o), 16'h0011);
    step(0, 0, 0, 0, 0, 0, 0, 8'h93, 0, 0, 8'hFF);
    chk("R4 mirror high", 16'(result_o), 16'h0011);
    step(2, 0, 0, 0, 1, 1, 0, 8'h12, 8'h13, 8'h12, 0);
    chk("R5 dual op", 16'(result_o), 16'h0055);
    step(0, 0, 0, 0, 1, 0, 0, 8'h12, 8'h12, 0, 0);
    chk("R5 dual written back", 16'(result_o), 16'h0055);
  endtask

  task automatic t_regs();
    step(0, 0, 0, 0, 0, 0, 0, 8'h05, 0, 0, 8'h0F);
    chk("R2 baseline", 16'(result_o), 16'h000D);
    @(negedge clk);
    op_i = 4'd1; data_i = 8'hF0;
    #1;
    chk("R2 held mid cycle", 16'(result_o), 16'h000D);
    @(posedge clk);
    #1;
    chk("R2 after edge", 16'(result_o), 16'h00FD);
  endtask

  task automatic t_chain();
    logic c;
    load_single(8'h50, 8'hF0);
    load_single(8'h51, 8'h12);
    step(3, 0, 0, 0, 0, 0, 0, 8'h50, 0, 0, 8'h30);
    c = carry_o;
    chk("R11 low byte", 16'(result_o), 16'h0020);
    step(3, 0, 0, c, 0, 0, 0, 8'h51, 0, 0, 8'h0E);
    chk("R11 high byte", 16'(result_o), 16'h0021);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_logic();
    t_add();
    t_invert();
    t_shift();
    t_mul();
    t_writeback();
    t_dual();
    t_regs();
    t_chain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule